// File: doc/BRIEF.md
# Serial Register Transfer Unit

This block moves a word from a source shift register into a destination shift register one bit per clock. A start request opens a shift window that lasts exactly as many enabled clocks as the registers have stages. A four-stage register therefore takes four shifts. A counter inside the block closes the window, so the requester only has to pulse start once.

Both registers shift right together, and only while the window is open. The source's least significant bit leaves first and enters the destination at its most significant bit. The destination's old contents fall out of its low end and are lost.

A mode bit, captured when the window opens, selects what refills the source during the window. It can refill with zeros, so the source ends empty. It can also recirculate its own outgoing bit, so the source ends holding its original word. The source can be loaded in parallel while the block is idle, and both registers can be read in parallel at any time. The shift gating is modelled as a clock enable, not a gated clock.

Top module: `serial_xfer_unit`

## Requirements
- R1: While rst_n is low at a clock edge, the source, the destination and busy_o all become 0.
- R2: A start_i pulse sampled while busy_o is low sets busy_o high on that edge. busy_o then stays high for exactly WIDTH clock cycles (4 by default) and falls by itself.
- R3: On every edge where busy_o is high, both registers shift right by one. The source bit 0 enters destination bit WIDTH-1, and destination bit 0 is discarded.
- R4: When busy_o falls, the destination holds the value the source had when the window opened.
- R5: With circ_i = 0 at start, the source's incoming bit is 0 during the window, so the source is all zeros at the end.
- R6: With circ_i = 1 at start, the source's outgoing bit 0 is fed back into its bit WIDTH-1, so the source ends with its original value.
- R7: circ_i is sampled only with an accepted start. Changing it during the window has no effect on the result.
- R8: start_i while busy_o is high is ignored. The window is not extended, and a new one does not begin until start_i is sampled again while idle.
- R9: load_i sampled while busy_o is low writes load_data_i into the source on that edge. load_i while busy_o is high is ignored.
- R10: While busy_o is low and load_i is low, both registers hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request to open a transfer window |
| circ_i | input | 1 | Source refill mode: 0 fills with zeros, 1 recirculates |
| load_i | input | 1 | Parallel load of the source when idle |
| load_data_i | input | WIDTH | Word for parallel load |
| src_q_o | output | WIDTH | Parallel read of the source register |
| dst_q_o | output | WIDTH | Parallel read of the destination register |
| busy_o | output | 1 | High while the shift window is open |

## Verification
Both registers are visible at the ports, so a bad bit in the shift path shows on dst_q_o or src_q_o on the very edge where it happens. A window-counter fault shows as busy_o falling one cycle early or late. A fault in the captured mode shows at the source's top bit on the first shift after start. A missed idle guard on load or start shows one clock after the ignored request.

// File: rtl/xfer_pkg.sv
// Shared types for the serial transfer unit.
// Assumes nothing beyond a single clock domain.
package xfer_pkg;
    typedef enum logic {
        FILL_ZERO = 1'b0,
        FILL_CIRC = 1'b1
    } fill_mode_e;
endpackage

// File: rtl/xfer_shreg.sv
// Right-shifting register with parallel load and a serial input at the MSB.
// Assumes shift_en and load_en are never high together; shift takes priority.
module xfer_shreg #(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             load_en,
    input  logic [WIDTH-1:0] load_val,
    input  logic             ser_in,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] q_r;

    // Register update: reset, shift right with ser_in at the top, load, or hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_r <= '0;
        end else if (shift_en) begin
            q_r <= {ser_in, q_r[WIDTH-1:1]};
        end else if (load_en) begin
            q_r <= load_val;
        end
    end

    assign q = q_r;
endmodule

// File: rtl/xfer_window.sv
// Self-timed shift window: opens on an idle start, closes after WIDTH shifts.
// Captures the refill mode when the window opens.
module xfer_window
    import xfer_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic       circ,
    output logic       busy,
    output fill_mode_e mode
);
    localparam int CNT_W = (WIDTH > 2) ? $clog2(WIDTH) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WIDTH - 1);

    logic [CNT_W-1:0] cnt_q;
    logic             busy_q;
    fill_mode_e       mode_q;

    // Window state: open on idle start, count shifts, close after the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            mode_q <= FILL_ZERO;
        end else if (busy_q) begin
            if (cnt_q == LAST) begin
                busy_q <= 1'b0;
                cnt_q  <= '0;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (start) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            mode_q <= circ ? FILL_CIRC : FILL_ZERO;
        end
    end

    assign busy = busy_q;
    assign mode = mode_q;
endmodule

// File: rtl/serial_xfer_unit.sv
// Top: source register shifts serially into destination register during a
// WIDTH-clock window. Source refills with zeros or recirculates per mode.
// Assumes synchronous active-low reset and a single clock.
module serial_xfer_unit
    import xfer_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             circ_i,
    input  logic             load_i,
    input  logic [WIDTH-1:0] load_data_i,
    output logic [WIDTH-1:0] src_q_o,
    output logic [WIDTH-1:0] dst_q_o,
    output logic             busy_o
);
    logic       busy;
    fill_mode_e mode;
    logic [WIDTH-1:0] src_q;
    logic [WIDTH-1:0] dst_q;
    logic       src_fill;
    logic       src_load;

    xfer_window #(.WIDTH(WIDTH)) u_window (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start_i),
        .circ  (circ_i),
        .busy  (busy),
        .mode  (mode)
    );

    // Source refill bit and idle-only load gate.
    always_comb begin
        src_fill = (mode == FILL_CIRC) ? src_q[0] : 1'b0;
        src_load = load_i & ~busy;
    end

    xfer_shreg #(.WIDTH(WIDTH)) u_src (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (busy),
        .load_en  (src_load),
        .load_val (load_data_i),
        .ser_in   (src_fill),
        .q        (src_q)
    );

    xfer_shreg #(.WIDTH(WIDTH)) u_dst (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (busy),
        .load_en  (1'b0),
        .load_val ({WIDTH{1'b0}}),
        .ser_in   (src_q[0]),
        .q        (dst_q)
    );

    assign src_q_o = src_q;
    assign dst_q_o = dst_q;
    assign busy_o  = busy;
endmodule

// File: rtl/xfer_checker.sv
// Port-level checker for serial_xfer_unit, attached by bind.
// Tracks window length and captured mode on its own.
module xfer_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             circ_i,
    input logic             load_i,
    input logic [WIDTH-1:0] load_data_i,
    input logic [WIDTH-1:0] src_q_o,
    input logic [WIDTH-1:0] dst_q_o,
    input logic             busy_o
);
    int   run_cnt;
    logic chk_mode;

    // Count cycles spent in the window and remember the mode taken at start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_cnt  <= 0;
            chk_mode <= 1'b0;
        end else begin
            run_cnt <= busy_o ? run_cnt + 1 : 0;
            if (!busy_o && start_i) chk_mode <= circ_i;
        end
    end

    AST_RESET_CLEAR: assert property (@(posedge clk) !rst_n |=> (busy_o == 1'b0 && src_q_o == '0 && dst_q_o == '0)); // R1
    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n) (start_i && !busy_o) |=> busy_o); // R2
    AST_WINDOW_BOUND: assert property (@(posedge clk) disable iff (!rst_n) busy_o |-> (run_cnt < WIDTH)); // R2
    AST_WINDOW_LEN: assert property (@(posedge clk) disable iff (!rst_n) $fell(busy_o) |-> (run_cnt == WIDTH)); // R8
    AST_DST_SERIAL: assert property (@(posedge clk) disable iff (!rst_n) busy_o |=> (dst_q_o[WIDTH-1] == $past(src_q_o[0]))); // R3
    AST_ZERO_FILL: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !chk_mode) |=> (src_q_o[WIDTH-1] == 1'b0)); // R5
    AST_CIRC_FILL: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && chk_mode) |=> (src_q_o[WIDTH-1] == $past(src_q_o[0]))); // R6
    AST_IDLE_LOAD: assert property (@(posedge clk) disable iff (!rst_n) (load_i && !busy_o) |=> (src_q_o == $past(load_data_i))); // R9
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!busy_o && !load_i) |=> ($stable(src_q_o) && $stable(dst_q_o))); // R10
endmodule

bind serial_xfer_unit xfer_checker #(.WIDTH(WIDTH)) u_xfer_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .circ_i      (circ_i),
    .load_i      (load_i),
    .load_data_i (load_data_i),
    .src_q_o     (src_q_o),
    .dst_q_o     (dst_q_o),
    .busy_o      (busy_o)
);

// File: tb/test_serial_xfer_unit.sv
module test_serial_xfer_unit;
    localparam int W = 4;
    localparam time CLK_PERIOD = 10ns;

    logic         clk = 1'b0;
    logic         rst_n;
    logic         start_i, circ_i, load_i;
    logic [W-1:0] load_data_i;
    logic [W-1:0] src_q_o, dst_q_o;
    logic         busy_o;

    int n_checks = 0;
    int n_fail   = 0;

    serial_xfer_unit #(.WIDTH(W)) i_serial_xfer_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .circ_i(circ_i),
        .load_i(load_i), .load_data_i(load_data_i),
        .src_q_o(src_q_o), .dst_q_o(dst_q_o), .busy_o(busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_load(input logic [W-1:0] v);
        load_i = 1'b1; load_data_i = v; tick(); load_i = 1'b0;
    endtask

    // Pulse start, then watch the window and return the final registers.
    task automatic run_xfer(input logic mode, output logic [W-1:0] s, output logic [W-1:0] d);
        start_i = 1'b1; circ_i = mode; tick(); start_i = 1'b0;
        for (int i = 0; i < W; i++) begin
            check(busy_o === 1'b1, "R2 busy in window", busy_o, 1);
            tick();
        end
        check(busy_o === 1'b0, "R2 busy closes", busy_o, 0);
        s = src_q_o; d = dst_q_o;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; start_i = 0; circ_i = 0; load_i = 0; load_data_i = '0;
        tick(); tick();
        check(src_q_o == '0 && dst_q_o == '0 && busy_o == 1'b0, "R1 reset", {src_q_o, dst_q_o}, 0);
        rst_n = 1'b1; tick();
    endtask

    task automatic t_zero_fill();
        logic [W-1:0] s, d;
        do_load(4'b1000);
        check(src_q_o == 4'b1000, "R9 idle load", src_q_o, 4'b1000);
        run_xfer(1'b0, s, d);
        check(d == 4'b1000, "R4 dst gets src", d, 4'b1000);
        check(s == 4'b0000, "R5 src zeroed", s, 0);
    endtask

    task automatic t_circulate();
        logic [W-1:0] s, d;
        do_load(4'b1011);
        run_xfer(1'b1, s, d);
        check(d == 4'b1011, "R4 dst gets src circ", d, 4'b1011);
        check(s == 4'b1011, "R6 src kept", s, 4'b1011);
    endtask

    task automatic t_first_shift();
        // dst holds 1011 from previous test; src loaded 0101
        do_load(4'b0101);
        start_i = 1'b1; circ_i = 1'b0; tick(); start_i = 1'b0;
        tick();
        check(dst_q_o == 4'b1101, "R3 first shift dst", dst_q_o, 4'b1101);
        check(src_q_o == 4'b0010, "R3 first shift src", src_q_o, 4'b0010);
        while (busy_o) tick();
        check(dst_q_o == 4'b0101, "R4 dst after", dst_q_o, 4'b0101);
    endtask

    task automatic t_mode_change();
        do_load(4'b0110);
        start_i = 1'b1; circ_i = 1'b1; tick(); start_i = 1'b0; circ_i = 1'b0;
        while (busy_o) tick();
        check(src_q_o == 4'b0110, "R7 mode held at start", src_q_o, 4'b0110);
    endtask

    task automatic t_start_busy();
        int len = 0;
        do_load(4'b1001);
        start_i = 1'b1; circ_i = 1'b0; tick();
        while (busy_o && len < 20) begin len++; tick(); end
        start_i = 1'b0;
        check(len == W, "R8 window not extended", len, W);
        // start was high on the closing edge while busy: still no new window
        check(busy_o == 1'b0, "R8 no restart", busy_o, 0);
    endtask

    task automatic t_load_busy();
        do_load(4'b1100);
        start_i = 1'b1; circ_i = 1'b1; tick(); start_i = 1'b0;
        load_i = 1'b1; load_data_i = 4'b0011;
        while (busy_o) tick();
        load_i = 1'b0;
        check(src_q_o == 4'b1100, "R9 load ignored when busy", src_q_o, 4'b1100);
        check(dst_q_o == 4'b1100, "R4 dst after busy load", dst_q_o, 4'b1100);
    endtask

    task automatic t_hold();
        logic [W-1:0] s0, d0;
        s0 = src_q_o; d0 = dst_q_o;
        load_data_i = 4'b0001;
        for (int i = 0; i < 5; i++) tick();
        check(src_q_o == s0 && dst_q_o == d0, "R10 idle hold", {src_q_o, dst_q_o}, {s0, d0});
    endtask

    initial begin
        t_reset();
        t_zero_fill();
        t_circulate();
        t_first_shift();
        t_mode_change();
        t_start_busy();
        t_load_busy();
        t_hold();
        t_reset();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 5000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule